// File: doc/BRIEF.md
# Load and Move Execution Unit

This unit executes five operations of a 32-bit instruction word:
- a register copy;
- a zero-extended immediate move;
- a move of an immediate that always comes out negative;
- a word load addressed by a register plus a scaled immediate;
- a word load addressed by the sum of two registers.

The unit reads the instruction's opcode and register fields. It drives the two register-file read addresses directly from the word. It returns one destination write through a registered write port.

A move completes one cycle after it is accepted. A load captures its address and raises a memory request. It holds that request until the memory acknowledges it, then waits for a response. A clean response is written to the destination register. A faulting response raises an exception pulse instead of the write.

Any opcode outside the five raises an illegal-instruction pulse. Immediates are split inside the word: the low four bits sit just above the opcode and the remaining bits sit at the top of the word.

Top module: `lmx_unit`

## Requirements
- R1: Field positions are fixed: opcode in instWord[6:0], destination register in [15:11], source register in [20:16] and offset register in [25:21]. rs1Addr shows [20:16] and rs2Addr shows [25:21]. An instruction is accepted on a rising edge where instValid is high and busy is low. Back-to-back instructions are accepted on consecutive cycles.
- R2: Opcode 0x0d (copy) gives, in the cycle after acceptance, a one-cycle wrEn with wrAddr = destination and wrData = rs1Data. All other bits have no effect.
- R3: Opcode 0x0e (immediate move) writes the 20-bit value {instWord[31:16], instWord[10:7]}, zero-extended to 32 bits, one cycle after acceptance.
- R4: Opcode 0x13 (negative move) writes the same 20-bit value minus 2^20, sign-extended to 32 bits. The result spans -1048576 (field 0) to -1 (field 0xFFFFF).
- R5: Opcode 0x01 (register+immediate load) addresses memory at rs1Data plus 4 times the signed 15-bit word count {instWord[31:21], instWord[10:7]}. Byte offsets therefore span -65536 to 65532.
- R6: Opcode 0x04 (register+register load) addresses memory at rs1Data + rs2Data. instWord[10:7] has no effect on the address.
- R7: memReq rises in the cycle after a load is accepted. It stays high, with memAddr stable, until a rising edge that sees memAck. It is low in the next cycle.
- R8: busy is high from the cycle after a load is accepted until the cycle after its response. Instructions presented while busy is high are ignored.
- R9: A response (memRspValid with memFault low) after the acknowledge gives, in the next cycle, a one-cycle wrEn with wrAddr = the load's destination and wrData = memRspData.
- R10: A response with memFault high gives, in the next cycle, a one-cycle faultExc pulse and no register write.
- R11: Any other opcode gives a one-cycle illegalOp pulse in the cycle after acceptance, with no write and no memory request.
- R12: While rstN is low and after its release, busy, wrEn, memReq, illegalOp and faultExc are low.
- R13: At most one of wrEn, illegalOp and faultExc is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| instValid | input | 1 | Instruction word is presented |
| instWord | input | 32 | Decoded instruction word |
| busy | output | 1 | Load in flight; new instructions are not taken |
| illegalOp | output | 1 | Unknown-opcode pulse |
| rs1Addr | output | 5 | Source register read address |
| rs1Data | input | 32 | Source register value |
| rs2Addr | output | 5 | Offset register read address |
| rs2Data | input | 32 | Offset register value |
| wrEn | output | 1 | Destination write strobe |
| wrAddr | output | 5 | Destination register |
| wrData | output | 32 | Destination write value |
| memReq | output | 1 | Word read request |
| memAddr | output | 32 | Word read byte address |
| memAck | input | 1 | Memory takes the request |
| memRspValid | input | 1 | Read response present |
| memRspData | input | 32 | Read response data |
| memFault | input | 1 | Response carries a memory fault |
| faultExc | output | 1 | Memory-fault exception pulse |

## Verification
The bench goes after the ends of both immediate ranges:
- If a design forgets the implied sign bit of the negative move, field 0 comes back as zero instead of -1048576.
- If a design sign-extends the positive move, a field with bit 19 set comes back with ones in the upper bits.
- If a design does not sign-extend or scale the load offset, the most negative and most positive word counts produce wrong addresses.

The bench holds the memory acknowledge back for several cycles. A design that drops the request early, or lets the address move while it waits, is caught there.

The bench presents moves while a load is outstanding. A design that accepts them emits an extra write.

A faulting response is checked for exactly one exception pulse and no write. A design that writes the fault data to the register is caught there.

Junk is placed in the unused bits of the copy and of the register-pair load, to catch any design that lets those bits leak into the result.

// File: rtl/lmx_pkg.sv
package lmx_pkg;

  localparam int OPC_W    = 7;
  localparam int REG_AW   = 5;
  localparam int MOVE_W   = 20;
  localparam int LOFF_W   = 15;
  localparam int INST_W   = 32;

  localparam logic [OPC_W-1:0] OPC_LD_IMM = 7'h01;
  localparam logic [OPC_W-1:0] OPC_LD_REG = 7'h04;
  localparam logic [OPC_W-1:0] OPC_COPY   = 7'h0d;
  localparam logic [OPC_W-1:0] OPC_MOVI   = 7'h0e;
  localparam logic [OPC_W-1:0] OPC_MOVN   = 7'h13;

  typedef enum logic [2:0] {
    OP_COPY, OP_MOVI, OP_MOVN, OP_LD_IMM, OP_LD_REG, OP_ILL
  } opKind_e;

  typedef enum logic [1:0] {
    SEL_COPY, SEL_MOVI, SEL_MOVN
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrMove;   // write a move result now
    srcSel_e srcSel;   // which move value
    logic    capAddr;  // capture a load address and destination
    logic    addrRr;   // register+register address form
    logic    wrRsp;    // write a clean memory response
  } lmxStrobe_t;

  function automatic opKind_e decodeOp(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_COPY:   return OP_COPY;
      OPC_MOVI:   return OP_MOVI;
      OPC_MOVN:   return OP_MOVN;
      OPC_LD_IMM: return OP_LD_IMM;
      OPC_LD_REG: return OP_LD_REG;
      default:    return OP_ILL;
    endcase
  endfunction

endpackage

// File: rtl/lmx_datapath.sv
module lmx_datapath
  import lmx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [INST_W-1:OPC_W]   instBody,
  input  lmxStrobe_t              strobe,
  output logic [REG_AW-1:0]       rs1Addr,
  input  logic [DATA_W-1:0]       rs1Data,
  output logic [REG_AW-1:0]       rs2Addr,
  input  logic [DATA_W-1:0]       rs2Data,
  input  logic [DATA_W-1:0]       memRspData,
  output logic                    wrEn,
  output logic [REG_AW-1:0]       wrAddr,
  output logic [DATA_W-1:0]       wrData,
  output logic [DATA_W-1:0]       memAddr
);

  localparam int MOVE_EXT = DATA_W - MOVE_W;
  localparam int LOFF_EXT = DATA_W - LOFF_W - 2;

  logic [REG_AW-1:0] dstField;
  logic [3:0]        immLow;
  logic [MOVE_W-1:0] moveImm;
  logic [LOFF_W-1:0] loadWords;
  logic [DATA_W-1:0] moveVal;
  logic [DATA_W-1:0] loadOffset;
  logic [DATA_W-1:0] loadAddr;
  logic [REG_AW-1:0] dstHold;

  // Field extraction (instBody bit n is instruction bit n)
  assign immLow    = instBody[10:7];
  assign dstField  = instBody[15:11];
  assign rs1Addr   = instBody[20:16];
  assign rs2Addr   = instBody[25:21];
  assign moveImm   = {instBody[31:16], immLow};
  assign loadWords = {instBody[31:21], immLow};

  // Word count -> signed byte offset
  assign loadOffset = {{LOFF_EXT{loadWords[LOFF_W-1]}}, loadWords, 2'b00};
  assign loadAddr   = strobe.addrRr ? (rs1Data + rs2Data) : (rs1Data + loadOffset);

  always_comb begin
    case (strobe.srcSel)
      SEL_MOVI: moveVal = {{MOVE_EXT{1'b0}}, moveImm};
      SEL_MOVN: moveVal = {{MOVE_EXT{1'b1}}, moveImm};
      default:  moveVal = rs1Data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn    <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
      memAddr <= '0;
      dstHold <= '0;
    end else begin
      wrEn <= strobe.wrMove | strobe.wrRsp;
      if (strobe.wrMove) begin
        wrAddr <= dstField;
        wrData <= moveVal;
      end else if (strobe.wrRsp) begin
        wrAddr <= dstHold;
        wrData <= memRspData;
      end
      if (strobe.capAddr) begin
        memAddr <= loadAddr;
        dstHold <= dstField;
      end
    end
  end

  // R9: a response write targets the destination captured with the load
  a_r9_rsp_dest: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrRsp |=> (wrAddr == $past(dstHold)));

endmodule

// File: rtl/lmx_control.sv
module lmx_control
  import lmx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic             memAck,
  input  logic             memRspValid,
  input  logic             memFault,
  output lmxStrobe_t       strobe,
  output logic             busy,
  output logic             memReq,
  output logic             illegalOp,
  output logic             faultExc
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;

  state_e  state;
  state_e  stateNext;
  opKind_e opKind;
  logic    accept;
  logic    rspDone;

  assign opKind  = decodeOp(opcode);
  assign accept  = instValid && (state == ST_IDLE);
  assign rspDone = (state == ST_WAIT) && memRspValid;
  assign busy    = (state != ST_IDLE);
  assign memReq  = (state == ST_REQ);

  always_comb begin
    strobe         = '0;
    strobe.srcSel  = SEL_COPY;
    stateNext      = state;
    case (opKind)
      OP_MOVI: strobe.srcSel = SEL_MOVI;
      OP_MOVN: strobe.srcSel = SEL_MOVN;
      default: strobe.srcSel = SEL_COPY;
    endcase
    strobe.addrRr = (opKind == OP_LD_REG);
    case (state)
      ST_IDLE: begin
        if (accept) begin
          case (opKind)
            OP_COPY, OP_MOVI, OP_MOVN: strobe.wrMove = 1'b1;
            OP_LD_IMM, OP_LD_REG: begin
              strobe.capAddr = 1'b1;
              stateNext      = ST_REQ;
            end
            default: ;
          endcase
        end
      end
      ST_REQ:  if (memAck) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (rspDone) begin
          strobe.wrRsp = !memFault;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      illegalOp <= 1'b0;
      faultExc  <= 1'b0;
    end else begin
      state     <= stateNext;
      illegalOp <= accept && (opKind == OP_ILL);
      faultExc  <= rspDone && memFault;
    end
  end

  // R7: an acknowledged request drops and the unit keeps waiting
  a_r7_ack_drops_req: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (!memReq && busy));

  // R8: a response ends the busy period
  a_r8_rsp_frees: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memReq && memRspValid) |=> !busy);

endmodule

// File: rtl/lmx_unit.sv
module lmx_unit
  import lmx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  output logic              busy,
  output logic              illegalOp,
  output logic [4:0]        rs1Addr,
  input  logic [DATA_W-1:0] rs1Data,
  output logic [4:0]        rs2Addr,
  input  logic [DATA_W-1:0] rs2Data,
  output logic              wrEn,
  output logic [4:0]        wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  input  logic              memAck,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              memFault,
  output logic              faultExc
);

  lmxStrobe_t strobe;

  lmx_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .instValid   (instValid),
    .opcode      (instWord[OPC_W-1:0]),
    .memAck      (memAck),
    .memRspValid (memRspValid),
    .memFault    (memFault),
    .strobe      (strobe),
    .busy        (busy),
    .memReq      (memReq),
    .illegalOp   (illegalOp),
    .faultExc    (faultExc)
  );

  lmx_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .instBody   (instWord[INST_W-1:OPC_W]),
    .strobe     (strobe),
    .rs1Addr    (rs1Addr),
    .rs1Data    (rs1Data),
    .rs2Addr    (rs2Addr),
    .rs2Data    (rs2Data),
    .memRspData (memRspData),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .memAddr    (memAddr)
  );

  // R7: a pending request holds itself and its address
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R9: a clean response is written with its data
  a_r9_rsp_write: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memReq && memRspValid && !memFault)
      |=> (wrEn && wrData == $past(memRspData)));

  // R10: a faulting response raises the exception and writes nothing
  a_r10_fault_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memReq && memRspValid && memFault) |=> (faultExc && !wrEn));

  // R11: an illegal opcode never starts a memory access
  a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (!memReq && !busy));

  // R13: one outcome per cycle
  a_r13_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrEn, illegalOp, faultExc}));

endmodule

// File: tb/test_lmx_unit.sv
module test_lmx_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        busy, illegalOp, wrEn, memReq, faultExc;
  logic [4:0]  rs1Addr, rs2Addr, wrAddr;
  logic [31:0] rs1Data, rs2Data, wrData, memAddr;
  logic        memAck = 1'b0;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        memFault = 1'b0;

  int nChecks = 0;
  int nFail = 0;

  typedef struct {
    int          kind;   // 0 write, 1 illegal, 2 fault
    logic [4:0]  addr;
    logic [31:0] data;
    string       req;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] regVal(input logic [4:0] i);
    return 32'hA5A5_0000 + ({27'b0, i} * 32'h0010_0011);
  endfunction

  assign rs1Data = regVal(rs1Addr);
  assign rs2Data = regVal(rs2Addr);

  lmx_unit i_lmx_unit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .busy(busy), .illegalOp(illegalOp),
    .rs1Addr(rs1Addr), .rs1Data(rs1Data), .rs2Addr(rs2Addr), .rs2Data(rs2Data),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memRspValid(memRspValid), .memRspData(memRspData), .memFault(memFault),
    .faultExc(faultExc)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Encoders
  function automatic logic [31:0] encMove(input logic [6:0] op, input logic [4:0] rd,
                                          input logic [19:0] v);
    return {v[19:4], rd, v[3:0], op};
  endfunction
  function automatic logic [31:0] encCopy(input logic [4:0] rd, input logic [4:0] rs,
                                          input logic [10:0] junkHi, input logic [3:0] junkLo);
    return {junkHi, rs, rd, junkLo, 7'h0d};
  endfunction
  function automatic logic [31:0] encLdImm(input logic [4:0] rd, input logic [4:0] rs,
                                           input logic [14:0] words);
    return {words[14:4], rs, rd, words[3:0], 7'h01};
  endfunction
  function automatic logic [31:0] encLdReg(input logic [4:0] rd, input logic [4:0] rs,
                                           input logic [4:0] ro, input logic [3:0] junk);
    return {6'b0, ro, rs, rd, junk, 7'h04};
  endfunction

  function automatic logic [31:0] expLdImm(input logic [4:0] rs, input logic [14:0] words);
    logic signed [14:0] w;
    int byteOff;
    w = words;
    byteOff = int'(w) * 4;
    return regVal(rs) + 32'(byteOff);
  endfunction

  task automatic pushItem(input int kind, input logic [4:0] a, input logic [31:0] d,
                          input string req);
    expItem_t e;
    e.kind = kind; e.addr = a; e.data = d; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic sendInst(input logic [31:0] w, input string req);
    @(negedge clk);
    instValid = 1'b1;
    instWord  = w;
    checkEq(req, "rs1Addr field", {27'b0, rs1Addr}, {27'b0, w[20:16]});
    @(negedge clk);
    instValid = 1'b0;
    instWord  = 32'hDEAD_BEEF;
  endtask

  // Monitor: compare every produced outcome with the scoreboard
  always @(negedge clk) begin
    expItem_t e;
    int k;
    if (rstN && (wrEn || illegalOp || faultExc)) begin
      k = wrEn ? 0 : (illegalOp ? 1 : 2);
      if (expQ.size() == 0) begin
        nChecks++;
        nFail++;
        $display("FAIL R8 unexpected outcome: actual kind %0d expected none", k);
      end else begin
        e = expQ.pop_front();
        checkEq(e.req, "outcome kind", 32'(k), 32'(e.kind));
        if (e.kind == 0 && k == 0) begin
          checkEq(e.req, "wrAddr", {27'b0, wrAddr}, {27'b0, e.addr});
          checkEq(e.req, "wrData", wrData, e.data);
        end
      end
    end
  end

  // Load driver with memory behaviour and a busy-time intruder
  task automatic doLoad(input logic [31:0] w, input logic [31:0] expAddr,
                        input int ackDelay, input int rspDelay, input logic fault,
                        input logic [31:0] rdata, input string req);
    if (fault) pushItem(2, '0, '0, "R10");
    else       pushItem(0, w[15:11], rdata, "R9");
    sendInst(w, req);
    checkEq("R7", "memReq after accept", {31'b0, memReq}, 32'd1);
    checkEq("R8", "busy after accept", {31'b0, busy}, 32'd1);
    checkEq(req, "memAddr", memAddr, expAddr);
    for (int i = 0; i < ackDelay; i++) begin
      @(negedge clk);
      checkEq("R7", "memReq held", {31'b0, memReq}, 32'd1);
      checkEq("R7", "memAddr held", memAddr, expAddr);
    end
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    checkEq("R7", "memReq after ack", {31'b0, memReq}, 32'd0);
    // R8: moves offered while busy must be ignored
    instValid = 1'b1;
    instWord  = encMove(7'h0e, 5'd9, 20'h00777);
    for (int i = 0; i < rspDelay; i++) begin
      @(negedge clk);
      checkEq("R8", "busy while waiting", {31'b0, busy}, 32'd1);
    end
    instValid   = 1'b0;
    memRspValid = 1'b1;
    memFault    = fault;
    memRspData  = rdata;
    @(negedge clk);
    memRspValid = 1'b0;
    memFault    = 1'b0;
    memRspData  = 32'h0BAD_0BAD;
    checkEq("R8", "busy after response", {31'b0, busy}, 32'd0);
    checkEq(fault ? "R10" : "R9", "faultExc", {31'b0, faultExc}, {31'b0, fault});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    checkEq("R12", "busy in reset", {31'b0, busy}, 32'd0);
    checkEq("R12", "wrEn in reset", {31'b0, wrEn}, 32'd0);
    checkEq("R12", "memReq in reset", {31'b0, memReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R12", "outputs after reset",
            {27'b0, busy, wrEn, memReq, illegalOp, faultExc}, 32'd0);

    // R2: copy with junk in unused fields
    pushItem(0, 5'd3, regVal(5'd7), "R2");
    sendInst(encCopy(5'd3, 5'd7, 11'h5A5, 4'hF), "R2");
    checkEq("R1", "rs2Addr field", {27'b0, rs2Addr}, {27'b0, instWord[25:21]});

    // R3: immediate move, zero extended
    pushItem(0, 5'd5, 32'h000A_BCDE, "R3");
    sendInst(encMove(7'h0e, 5'd5, 20'hABCDE), "R3");
    pushItem(0, 5'd31, 32'h000F_FFFF, "R3");
    sendInst(encMove(7'h0e, 5'd31, 20'hFFFFF), "R3");

    // R4: negative move range ends and a middle value
    pushItem(0, 5'd1, 32'hFFF0_0000, "R4");
    sendInst(encMove(7'h13, 5'd1, 20'h00000), "R4");
    pushItem(0, 5'd2, 32'hFFFF_FFFF, "R4");
    sendInst(encMove(7'h13, 5'd2, 20'hFFFFF), "R4");
    pushItem(0, 5'd4, 32'hFFF1_2345, "R4");
    sendInst(encMove(7'h13, 5'd4, 20'h12345), "R4");

    // R1: back-to-back acceptance on consecutive cycles
    pushItem(0, 5'd6, 32'h0000_0011, "R1");
    pushItem(0, 5'd8, 32'hFFF0_0022, "R1");
    @(negedge clk);
    instValid = 1'b1;
    instWord  = encMove(7'h0e, 5'd6, 20'h00011);
    @(negedge clk);
    instWord  = encMove(7'h13, 5'd8, 20'h00022);
    @(negedge clk);
    instValid = 1'b0;

    // R11: illegal opcodes
    pushItem(1, '0, '0, "R11");
    sendInst(32'h0000_007F, "R11");
    checkEq("R11", "no request on illegal", {31'b0, memReq}, 32'd0);
    pushItem(1, '0, '0, "R11");
    sendInst(encLdImm(5'd3, 5'd4, 15'h0002) ^ 32'h0000_0003, "R11");

    // R5: register+immediate loads
    doLoad(encLdImm(5'd10, 5'd2, 15'h0002), expLdImm(5'd2, 15'h0002),
           2, 1, 1'b0, 32'h1234_5678, "R5");
    doLoad(encLdImm(5'd11, 5'd3, 15'h4000), expLdImm(5'd3, 15'h4000),
           0, 2, 1'b0, 32'hCAFE_F00D, "R5");
    checkEq("R5", "min offset address", expLdImm(5'd3, 15'h4000),
            regVal(5'd3) - 32'd65536);
    doLoad(encLdImm(5'd12, 5'd4, 15'h3FFF), regVal(5'd4) + 32'd65532,
           3, 0, 1'b0, 32'h0000_FFFF, "R5");
    doLoad(encLdImm(5'd13, 5'd5, 15'h7FFF), regVal(5'd5) - 32'd4,
           1, 1, 1'b0, 32'h8000_0001, "R5");

    // R6: register+register load with junk in bits 10:7
    doLoad(encLdReg(5'd14, 5'd6, 5'd9, 4'hA), regVal(5'd6) + regVal(5'd9),
           1, 3, 1'b0, 32'h7777_1111, "R6");

    // R10: faulting load, then a move still works
    doLoad(encLdReg(5'd15, 5'd1, 5'd2, 4'h0), regVal(5'd1) + regVal(5'd2),
           2, 1, 1'b1, 32'hFFFF_0000, "R10");
    pushItem(0, 5'd16, regVal(5'd20), "R2");
    sendInst(encCopy(5'd16, 5'd20, 11'h000, 4'h0), "R2");

    repeat (4) @(negedge clk);
    checkEq("R13", "scoreboard drained", 32'(expQ.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule